// File: doc/BRIEF.md
# Load/Store Alignment Guard

This block sits in the memory stage of a small in-order processor, beside the request path to the data bus. For every load or store request it decides within the same cycle whether the address suits the access size. If the address is misaligned, it decides whether the instruction class may go ahead unaligned or must raise a usage fault. When a fault is raised, the bus request is withheld in that same cycle, so no memory beat is ever issued for a faulting access.

The access size code and a class code describe each request. Store, unprivileged and signed-load flags travel with the request. A trap-enable configuration bit turns every misaligned access into a fault. Only a fixed group of single word and halfword load/store classes may ever run unaligned. Dual-word, multiple-word and exclusive classes always fault on a misaligned address.

A raised fault is registered into a record that holds the cause, the address and the request flags. The record stays put until the exception logic acknowledges it. Splitting an unaligned access into bus beats, and the exception entry itself, are left to other blocks.

Top module: `lsu_align_guard`

## Requirements
- R1: A byte access (size code 0) is always reported aligned and never raises an alignment fault, whatever the address, class or trap bit.
- R2: A halfword access (size code 1) is reported aligned exactly when address bit 0 is zero.
- R3: Word, dual-word and multiple-word accesses (size codes 2, 3, 4) are reported aligned exactly when address bits [1:0] are both zero.
- R4: With the trap bit clear, `permit_unal_o` is 1 for class codes 0 to 4 (word load, word store, halfword load, halfword store, signed halfword load, each with or without the unprivileged flag) and 0 for class codes 5 to 7 (dual, multiple, exclusive).
- R5: With the trap bit set, `permit_unal_o` is 0 for every class, so any misaligned access faults.
- R6: A valid request faults when its size code is 5 to 7 or when it is misaligned and not permitted. In that same cycle `mem_valid_o` is 0. Otherwise `mem_valid_o` equals `req_valid_i`.
- R7: After a faulting cycle with no record held, the next cycle shows `fault_valid_o`=1, `fault_addr_o` equal to the request address, and `fault_attr_o` = {signed, unprivileged, store}. For a misaligned fault, `fault_cause_o` is 1.
- R8: A size code of 5, 6 or 7 records cause 2, which takes priority over cause 1.
- R9: A held record stays unchanged until `fault_ack_i` is 1. A later fault that arrives while the record is held and not acknowledged does not overwrite it. An acknowledge with no new fault clears `fault_valid_o` and sets the cause to 0.
- R10: When an acknowledge and a new fault fall in the same cycle, the new fault's record replaces the old one on the next cycle.
- R11: The signed, store and unprivileged flags never change `aligned_o`, `permit_unal_o` or `mem_valid_o`.
- R12: During and right after reset, `fault_valid_o` is 0 and `fault_cause_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Load/store request present |
| addr_i | input | ADDR_W | Request byte address |
| size_i | input | 3 | Access size: 0 byte, 1 halfword, 2 word, 3 dual, 4 multiple, 5-7 illegal |
| iclass_i | input | 3 | Instruction class: 0 word ld, 1 word st, 2 half ld, 3 half st, 4 signed half ld, 5 dual, 6 multiple, 7 exclusive |
| store_i | input | 1 | Request is a store |
| unpriv_i | input | 1 | Unprivileged-variant access |
| signed_i | input | 1 | Signed-load flag |
| trap_unal_i | input | 1 | Configuration: fault on every misaligned access |
| fault_ack_i | input | 1 | Exception logic takes the held fault |
| aligned_o | output | 1 | Address suits the access size |
| permit_unal_o | output | 1 | Class may run unaligned under current configuration |
| mem_valid_o | output | 1 | Request forwarded to the bus |
| fault_valid_o | output | 1 | Fault record held |
| fault_cause_o | output | 2 | 0 none, 1 misaligned, 2 illegal size |
| fault_addr_o | output | ADDR_W | Address of the recorded fault |
| fault_attr_o | output | 3 | {signed, unprivileged, store} of the recorded fault |

## Verification
The case that needs the most care is when the exception logic acknowledges a held record in the same cycle that a new faulting request arrives. The record must then swap to the new fault rather than clear. The second case is a new fault that arrives while an older record is still held without acknowledge, and that fault must leave the record alone. The bench forces both cases by directed sequences and raises acknowledge at random alongside random faults. A bench model computes the next record from the rules above, and it is compared with the registered outputs one cycle later.

// File: rtl/align_pkg.sv
package align_pkg;
    localparam int SIZE_W  = 3;
    localparam int CLASS_W = 3;
    localparam int ATTR_W  = 3;

    localparam logic [SIZE_W-1:0] SZ_BYTE  = 3'd0;
    localparam logic [SIZE_W-1:0] SZ_HALF  = 3'd1;
    localparam logic [SIZE_W-1:0] SZ_WORD  = 3'd2;
    localparam logic [SIZE_W-1:0] SZ_DUAL  = 3'd3;
    localparam logic [SIZE_W-1:0] SZ_MULTI = 3'd4;

    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'd0,
        CAUSE_UNALIGNED = 2'd1,
        CAUSE_BAD_SIZE  = 2'd2
    } cause_e;
endpackage

// File: rtl/align_decode.sv
module align_decode
    import align_pkg::*;
(
    input  logic [SIZE_W-1:0] size_i,
    input  logic [1:0]        addr_lo_i,
    output logic              aligned_o,
    output logic              bad_size_o
);
    always_comb begin
        aligned_o  = 1'b1;
        bad_size_o = 1'b0;
        unique case (size_i)
            SZ_BYTE:  aligned_o = 1'b1;
            SZ_HALF:  aligned_o = (addr_lo_i[0] == 1'b0);
            SZ_WORD,
            SZ_DUAL,
            SZ_MULTI: aligned_o = (addr_lo_i == 2'b00);
            default:  bad_size_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/align_policy.sv
module align_policy
    import align_pkg::*;
#(
    parameter logic [(1<<CLASS_W)-1:0] PERMIT_MASK = 8'b0001_1111
) (
    input  logic [CLASS_W-1:0] iclass_i,
    input  logic               trap_unal_i,
    output logic               permit_o
);
    always_comb begin
        permit_o = PERMIT_MASK[iclass_i] & ~trap_unal_i;
    end
endmodule

// File: rtl/fault_hold.sv
module fault_hold
    import align_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  cause_e            cause_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ATTR_W-1:0] attr_i,
    input  logic              ack_i,
    output logic              valid_o,
    output cause_e            cause_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ATTR_W-1:0] attr_o
);
    typedef struct packed {
        logic              valid;
        cause_e            cause;
        logic [ADDR_W-1:0] addr;
        logic [ATTR_W-1:0] attr;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (capture_i && (!rec_q.valid || ack_i)) begin
            rec_d.valid = 1'b1;
            rec_d.cause = cause_i;
            rec_d.addr  = addr_i;
            rec_d.attr  = attr_i;
        end else if (ack_i) begin
            rec_d.valid = 1'b0;
            rec_d.cause = CAUSE_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '{valid: 1'b0, cause: CAUSE_NONE, addr: '0, attr: '0};
        end else begin
            rec_q <= rec_d;
        end
    end

    assign valid_o = rec_q.valid;
    assign cause_o = rec_q.cause;
    assign addr_o  = rec_q.addr;
    assign attr_o  = rec_q.attr;

    assert_hold_record_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ack_i) |=> (valid_o && $stable(cause_o) && $stable(addr_o) && $stable(attr_o)));

    assert_ack_replace_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ack_i && capture_i) |=> (valid_o && addr_o == $past(addr_i) && cause_o == $past(cause_i)));

    assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !capture_i) |=> (!valid_o && cause_o == CAUSE_NONE));

    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && capture_i) |=> (valid_o && attr_o == $past(attr_i)));
endmodule

// File: rtl/lsu_align_guard.sv
module lsu_align_guard
    import align_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        size_i,
    input  logic [2:0]        iclass_i,
    input  logic              store_i,
    input  logic              unpriv_i,
    input  logic              signed_i,
    input  logic              trap_unal_i,
    input  logic              fault_ack_i,
    output logic              aligned_o,
    output logic              permit_unal_o,
    output logic              mem_valid_o,
    output logic              fault_valid_o,
    output logic [1:0]        fault_cause_o,
    output logic [ADDR_W-1:0] fault_addr_o,
    output logic [2:0]        fault_attr_o
);
    logic   bad_size;
    logic   fault_now;
    cause_e cause_now;
    cause_e cause_held;

    align_decode u_decode (
        .size_i     (size_i),
        .addr_lo_i  (addr_i[1:0]),
        .aligned_o  (aligned_o),
        .bad_size_o (bad_size)
    );

    align_policy u_policy (
        .iclass_i    (iclass_i),
        .trap_unal_i (trap_unal_i),
        .permit_o    (permit_unal_o)
    );

    always_comb begin
        fault_now   = req_valid_i & (bad_size | (~aligned_o & ~permit_unal_o));
        cause_now   = bad_size ? CAUSE_BAD_SIZE : CAUSE_UNALIGNED;
        mem_valid_o = req_valid_i & ~fault_now;
    end

    fault_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (fault_now),
        .cause_i   (cause_now),
        .addr_i    (addr_i),
        .attr_i    ({signed_i, unpriv_i, store_i}),
        .ack_i     (fault_ack_i),
        .valid_o   (fault_valid_o),
        .cause_o   (cause_held),
        .addr_o    (fault_addr_o),
        .attr_o    (fault_attr_o)
    );

    assign fault_cause_o = cause_held;

    assert_byte_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_BYTE) |-> (aligned_o && (mem_valid_o == req_valid_i)));

    assert_half_odd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == SZ_HALF && addr_i[0]) |-> !aligned_o);

    assert_word_misaligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((size_i == SZ_WORD || size_i == SZ_DUAL || size_i == SZ_MULTI) && addr_i[1:0] != 2'b00) |-> !aligned_o);

    assert_trap_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_unal_i |-> !permit_unal_o);

    assert_no_bus_on_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !aligned_o && !permit_unal_o) |-> !mem_valid_o);

    assert_bad_size_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && size_i > SZ_MULTI && !fault_valid_o) |=> (fault_cause_o == 2'd2));
endmodule

// File: tb/lsu_align_guard_tb.sv
module lsu_align_guard_tb;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [2:0]    size_i = '0;
    logic [2:0]    iclass_i = '0;
    logic          store_i = 1'b0, unpriv_i = 1'b0, signed_i = 1'b0;
    logic          trap_unal_i = 1'b0, fault_ack_i = 1'b0;
    logic          aligned_o, permit_unal_o, mem_valid_o, fault_valid_o;
    logic [1:0]    fault_cause_o;
    logic [AW-1:0] fault_addr_o;
    logic [2:0]    fault_attr_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // model of the fault record
    bit            m_valid = 0;
    int            m_cause = 0;
    logic [AW-1:0] m_addr = '0;
    logic [2:0]    m_attr = '0;

    always #10 clk = ~clk;

    lsu_align_guard #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .addr_i(addr_i),
        .size_i(size_i), .iclass_i(iclass_i), .store_i(store_i), .unpriv_i(unpriv_i),
        .signed_i(signed_i), .trap_unal_i(trap_unal_i), .fault_ack_i(fault_ack_i),
        .aligned_o(aligned_o), .permit_unal_o(permit_unal_o), .mem_valid_o(mem_valid_o),
        .fault_valid_o(fault_valid_o), .fault_cause_o(fault_cause_o),
        .fault_addr_o(fault_addr_o), .fault_attr_o(fault_attr_o)
    );

    function automatic bit exp_aligned(input logic [2:0] sz, input logic [AW-1:0] a);
        case (sz)
            3'd0: return 1'b1;
            3'd1: return a[0] == 1'b0;
            3'd2, 3'd3, 3'd4: return a[1:0] == 2'b00;
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit exp_permit(input logic [2:0] cls, input logic tr);
        return (cls <= 3'd4) && !tr;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_record(input string tag);
        check(fault_valid_o == m_valid, {"R9 record valid ", tag}, fault_valid_o, m_valid);
        check(fault_cause_o == 2'(m_cause), {"R7 record cause ", tag}, fault_cause_o, m_cause);
        if (m_valid) begin
            check(fault_addr_o == m_addr, {"R7 record addr ", tag}, fault_addr_o, m_addr);
            check(fault_attr_o == m_attr, {"R7 record attr ", tag}, fault_attr_o, m_attr);
        end
    endtask

    task automatic step(input bit v, input logic [AW-1:0] a, input logic [2:0] sz,
                        input logic [2:0] cls, input bit st, input bit up, input bit sg,
                        input bit tr, input bit ak, input string tag);
        bit ea, ep, bad, fnow;
        @(negedge clk);
        check_record(tag);
        req_valid_i = v; addr_i = a; size_i = sz; iclass_i = cls;
        store_i = st; unpriv_i = up; signed_i = sg; trap_unal_i = tr; fault_ack_i = ak;
        #1;
        ea   = exp_aligned(sz, a);
        ep   = exp_permit(cls, tr);
        bad  = sz > 3'd4;
        fnow = v && (bad || (!ea && !ep));
        check(aligned_o == ea,
              {(sz == 3'd0) ? "R1" : (sz == 3'd1) ? "R2" : "R3", " aligned ", tag}, aligned_o, ea);
        check(permit_unal_o == ep, {tr ? "R5" : "R4", " permit ", tag}, permit_unal_o, ep);
        check(mem_valid_o == (v && !fnow), {"R6 mem_valid ", tag}, mem_valid_o, v && !fnow);
        if (fnow && (!m_valid || ak)) begin
            m_valid = 1; m_cause = bad ? 2 : 1; m_addr = a; m_attr = {sg, up, st};
        end else if (ak) begin
            m_valid = 0; m_cause = 0;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit sg0;
        repeat (2) @(negedge clk);
        // R12: reset state
        check(fault_valid_o == 1'b0, "R12 reset valid", fault_valid_o, 0);
        check(fault_cause_o == 2'd0, "R12 reset cause", fault_cause_o, 0);
        rst_n = 1'b1;
        step(0, 32'h0, 3'd0, 3'd0, 0, 0, 0, 0, 0, "R12 after reset");

        // R1: byte at odd address, faulting class, trap set
        step(1, 32'h1003, 3'd0, 3'd6, 1, 0, 0, 1, 0, "R1 byte");
        // R2 / R4: halfword even then odd with permitted class
        step(1, 32'h2002, 3'd1, 3'd3, 1, 0, 0, 0, 0, "R2 even");
        step(1, 32'h2001, 3'd1, 3'd3, 1, 0, 0, 0, 0, "R2 R4 odd permitted");
        // R3 / R6 / R7: dual word misaligned faults
        step(1, 32'h3002, 3'd3, 3'd5, 0, 1, 0, 0, 0, "R3 R6 dual fault");
        // R9: second fault while held, no ack
        step(1, 32'h4001, 3'd2, 3'd6, 1, 0, 0, 0, 0, "R9 held");
        step(0, 32'h0, 3'd0, 3'd0, 0, 0, 0, 0, 0, "R9 hold observe");
        // R10: ack together with new fault (R5 trap on permitted word load)
        step(1, 32'h5003, 3'd2, 3'd0, 0, 0, 1, 1, 1, "R10 R5 ack+fault");
        step(0, 32'h0, 3'd0, 3'd0, 0, 0, 0, 0, 1, "R9 ack clear");
        // R8: illegal size wins over misalignment
        step(1, 32'h6001, 3'd6, 3'd7, 0, 0, 0, 1, 0, "R8 bad size");
        step(0, 32'h0, 3'd0, 3'd0, 0, 0, 0, 0, 1, "R8 ack");
        // R11: flags toggled on identical requests
        for (int k = 0; k < 8; k++)
            step(1, 32'h7001, 3'd1, 3'd4, k[0], k[1], k[2], 0, 0, "R11 flags");
        for (int k = 0; k < 8; k++)
            step(1, 32'h7002, 3'd2, 3'd1, k[0], k[1], k[2], 0, 1, "R11 flags word");

        // random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] sz;
            sz  = ($urandom % 10 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
            sg0 = 1'($urandom);
            step(($urandom % 8) != 0, $urandom, sz, 3'($urandom),
                 1'($urandom), 1'($urandom), sg0, ($urandom % 4) == 0,
                 ($urandom % 3) == 0, "random");
        end
        step(0, 32'h0, 3'd0, 3'd0, 0, 0, 0, 0, 0, "final");
        @(negedge clk);
        check_record("final record");

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule